// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block turns a 6-bit operand specifier into an operand location for a 16-bit processor datapath. The upper three bits of the specifier choose an addressing mode and the lower three bits choose one of eight registers. Registers 0 to 6 come from the register file. Register 7 is the program counter. The block either reports that the operand lives in the register itself, or produces the memory address of the operand. It also reports any register update the mode implies and how far the program counter moved.

The indexed modes need an extension word, and the deferred modes need a pointer word. The block reads these through a single word-read port. The port holds a request and its address until the memory returns data with a valid strobe. The decoder in front raises `start_i` for one cycle with the specifier, the byte/word flag and the current register and PC values. The block answers with a one-cycle `done_o`, and the result ports keep their values until the next completion.

Top module: `opnd_ea_seq`

## Requirements
- R1: Mode 0 (specifier bits 5:3 = 0) completes with `done_o` in the cycle after `start_i`, with `reg_direct_o`=1, no writeback and no memory read. Modes 0, 1, 2 and 4 all complete in the cycle after `start_i`.
- R2: Mode 1 returns the selected register value as the address and updates no register.
- R3: Mode 2 returns the register value as the address and writes back the register plus the step.
- R4: Mode 4 subtracts the step from the register, writes that value back and returns it as the address.
- R5: The step is 1 only for a byte access (`byte_i`=1) through registers 0 to 5 in modes 2 and 4. In every other case it is 2: word accesses, deferred modes 3 and 5, and registers 6 and 7.
- R6: Mode 3 reads a pointer at the register value and writes back the register plus 2. Mode 5 writes back the register minus 2 and reads a pointer at that value. In both modes the address is the word read.
- R7: Modes 6 and 7 read an extension word at the PC, report `pc_adv_o`=2 and form the sum of the base and the extension word. Mode 6 returns that sum. Mode 7 reads a pointer at the sum and returns the word read.
- R8: With register 7 the base is the PC. Modes 2 and 3 report `pc_adv_o`=2 instead of a writeback, so mode 2 addresses the immediate word at the PC and mode 3 reads an absolute address there. Modes 6 and 7 use PC+2 as the base. Modes 4 and 5 write PC-2 back to register 7.
- R9: If a word access ends on an odd address, or a word read (pointer or extension) would start at an odd address, `err_o` is set with `done_o`. Any read that would start at an odd address is not issued. On an error `wb_en_o`=0 and `pc_adv_o`=0.
- R10: `rd_req_o` and `rd_addr_o` hold steady until `rd_valid_i` is sampled high. A read is consumed only on that edge, and reads are issued in the order extension word, then pointer.
- R11: `start_i` while `busy_o`=1 is ignored. The operation in flight completes with its own result, and no second completion follows.
- R12: After reset, `busy_o`, `done_o` and `rd_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin resolving `spec_i` (accepted only when idle) |
| spec_i | input | 6 | Mode in bits 5:3, register number in bits 2:0 |
| byte_i | input | 1 | 1 for byte operand, 0 for word |
| regs_i | input | 112 | Registers 0..6, register n at bits 16n+15:16n |
| pc_i | input | 16 | Current PC (register 7) |
| rd_req_o | output | 1 | Word read request |
| rd_addr_o | output | 16 | Word read address |
| rd_valid_i | input | 1 | Read data valid; consumes the request |
| rd_data_i | input | 16 | Read data |
| busy_o | output | 1 | An operation is waiting on memory |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Alignment error for the completed operation |
| reg_direct_o | output | 1 | Operand is the register itself |
| ea_o | output | 16 | Effective address |
| wb_en_o | output | 1 | Register update requested |
| wb_idx_o | output | 3 | Register to update |
| wb_val_o | output | 16 | New register value |
| pc_adv_o | output | 3 | Bytes the PC advanced (0 or 2) |

## Verification
A wrong step size or base selection shows at the next `done_o` as a wrong `wb_val_o` or `ea_o`. That is one cycle after start for the direct modes and right after the last read for the others. A corrupted latched mode or register number shows up one read earlier, as a wrong or missing request address or the wrong count of reads. A lost alignment decision appears as `err_o` disagreeing in the completion cycle, together with a stray writeback or PC advance. A state machine that fails to return to idle shows as `busy_o` still high, or a second `done_o`, in the cycle after completion.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_REG    = 3'd0,
        AM_DEF    = 3'd1,
        AM_INC    = 3'd2,
        AM_INCDEF = 3'd3,
        AM_DEC    = 3'd4,
        AM_DECDEF = 3'd5,
        AM_IDX    = 3'd6,
        AM_IDXDEF = 3'd7
    } am_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXT,
        ST_PTR
    } st_e;

    typedef struct packed {
        logic fin;
        logic pre_err;
        logic rdir;
    } fin_t;

    function automatic logic is_ptr_mode(am_e m);
        return (m == AM_INCDEF) || (m == AM_DECDEF) || (m == AM_IDXDEF);
    endfunction
endpackage

// File: rtl/ea_stepper.sv
module ea_stepper
    import ea_pkg::*;
#(
    parameter int W      = 16,
    parameter int RIW    = 3,
    parameter int SP_IDX = 6
) (
    input  am_e            mode,
    input  logic [RIW-1:0] ridx,
    input  logic           is_byte,
    input  logic [W-1:0]   base,
    output logic [W-1:0]   inc_val,
    output logic [W-1:0]   dec_val
);
    logic           unit_step;
    logic [W-1:0]   step;

    assign unit_step = is_byte && (ridx < RIW'(SP_IDX)) && !is_ptr_mode(mode);
    assign step      = unit_step ? W'(1) : W'(2);
    assign inc_val   = base + step;
    assign dec_val   = base - step;
endmodule

// File: rtl/ea_align_chk.sv
module ea_align_chk #(
    parameter int W = 16
) (
    input  logic [W-1:0] addr,
    input  logic         word_acc,
    output logic         misaligned
);
    assign misaligned = word_acc && addr[0];
endmodule

// File: rtl/opnd_ea_seq.sv
module opnd_ea_seq
    import ea_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [MODE_W+$clog2(NREG)-1:0] spec_i,
    input  logic                  byte_i,
    input  logic [(NREG-1)*W-1:0] regs_i,
    input  logic [W-1:0]          pc_i,
    output logic                  rd_req_o,
    output logic [W-1:0]          rd_addr_o,
    input  logic                  rd_valid_i,
    input  logic [W-1:0]          rd_data_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  err_o,
    output logic                  reg_direct_o,
    output logic [W-1:0]          ea_o,
    output logic                  wb_en_o,
    output logic [$clog2(NREG)-1:0] wb_idx_o,
    output logic [W-1:0]          wb_val_o,
    output logic [2:0]            pc_adv_o
);
    localparam int RIW    = $clog2(NREG);
    localparam int SPW    = MODE_W + RIW;
    localparam int PC_IDX = NREG - 1;
    localparam int SP_IDX = NREG - 2;

    // register view: file entries plus the PC in the top slot
    logic [W-1:0] rv [NREG];
    for (genvar g = 0; g < NREG - 1; g++) begin : g_unpack
        assign rv[g] = regs_i[g*W +: W];
    end
    assign rv[PC_IDX] = pc_i;

    // specifier decode at start
    am_e            s_mode;
    logic [RIW-1:0] s_ridx;
    logic [W-1:0]   s_base, s_inc, s_dec;
    logic           s_is_pc;

    assign s_mode  = am_e'(spec_i[SPW-1:RIW]);
    assign s_ridx  = spec_i[RIW-1:0];
    assign s_base  = rv[s_ridx];
    assign s_is_pc = (s_ridx == RIW'(PC_IDX));

    ea_stepper #(.W(W), .RIW(RIW), .SP_IDX(SP_IDX)) u_step (
        .mode(s_mode), .ridx(s_ridx), .is_byte(byte_i), .base(s_base),
        .inc_val(s_inc), .dec_val(s_dec)
    );

    // latched context
    st_e            state, nxt_state;
    am_e            mode_q;
    logic [RIW-1:0] reg_q;
    logic           byte_q;
    logic [W-1:0]   base_q, pc_q, raddr_q, nxt_raddr;
    logic           pend_wb_en;
    logic [W-1:0]   pend_wb_val;
    logic [2:0]     pend_pcadv;

    // side effects implied by the specifier
    logic           st_wb_en;
    logic [W-1:0]   st_wb_val;
    logic [2:0]     st_pcadv;

    always_comb begin
        st_wb_en  = 1'b0;
        st_wb_val = s_base;
        st_pcadv  = 3'd0;
        unique case (s_mode)
            AM_INC, AM_INCDEF: begin
                if (s_is_pc) st_pcadv = 3'd2;
                else begin
                    st_wb_en  = 1'b1;
                    st_wb_val = s_inc;
                end
            end
            AM_DEC, AM_DECDEF: begin
                st_wb_en  = 1'b1;
                st_wb_val = s_dec;
            end
            AM_IDX, AM_IDXDEF: st_pcadv = 3'd2;
            default: ;
        endcase
    end

    // sequencing
    fin_t         f;
    logic [W-1:0] fin_ea, req_addr, ext_sum;
    logic         req_go, ra_bad, ea_bad, fin_err, cur_byte;
    st_e          req_tgt;

    assign ext_sum  = ((reg_q == RIW'(PC_IDX)) ? pc_q + W'(2) : base_q) + rd_data_i;
    assign cur_byte = (state == ST_IDLE) ? byte_i : byte_q;

    ea_align_chk #(.W(W)) u_rchk (.addr(req_addr), .word_acc(1'b1),      .misaligned(ra_bad));
    ea_align_chk #(.W(W)) u_echk (.addr(fin_ea),   .word_acc(!cur_byte), .misaligned(ea_bad));

    always_comb begin
        f         = '0;
        fin_ea    = '0;
        req_go    = 1'b0;
        req_addr  = '0;
        req_tgt   = ST_PTR;
        nxt_state = state;
        nxt_raddr = raddr_q;
        unique case (state)
            ST_IDLE: if (start_i) begin
                unique case (s_mode)
                    AM_REG:         begin f.fin = 1'b1; f.rdir = 1'b1; end
                    AM_DEF, AM_INC: begin f.fin = 1'b1; fin_ea = s_base; end
                    AM_DEC:         begin f.fin = 1'b1; fin_ea = s_dec; end
                    AM_INCDEF:      begin req_go = 1'b1; req_addr = s_base; end
                    AM_DECDEF:      begin req_go = 1'b1; req_addr = s_dec; end
                    AM_IDX, AM_IDXDEF: begin
                        req_go = 1'b1; req_addr = pc_i; req_tgt = ST_EXT;
                    end
                    default: ;
                endcase
            end
            ST_EXT: if (rd_valid_i) begin
                if (mode_q == AM_IDX) begin
                    f.fin = 1'b1; fin_ea = ext_sum; nxt_state = ST_IDLE;
                end else begin
                    req_go = 1'b1; req_addr = ext_sum;
                end
            end
            ST_PTR: if (rd_valid_i) begin
                f.fin = 1'b1; fin_ea = rd_data_i; nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
        if (req_go) begin
            if (ra_bad) begin
                f.fin = 1'b1; f.pre_err = 1'b1; nxt_state = ST_IDLE;
            end else begin
                nxt_state = req_tgt; nxt_raddr = req_addr;
            end
        end
    end

    assign fin_err = f.pre_err || (!f.rdir && ea_bad);

    logic           p_wb_en;
    logic [W-1:0]   p_wb_val;
    logic [2:0]     p_pcadv;
    logic [RIW-1:0] p_idx;
    assign p_wb_en  = (state == ST_IDLE) ? st_wb_en  : pend_wb_en;
    assign p_wb_val = (state == ST_IDLE) ? st_wb_val : pend_wb_val;
    assign p_pcadv  = (state == ST_IDLE) ? st_pcadv  : pend_pcadv;
    assign p_idx    = (state == ST_IDLE) ? s_ridx    : reg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            raddr_q      <= '0;
            mode_q       <= AM_REG;
            reg_q        <= '0;
            byte_q       <= 1'b0;
            base_q       <= '0;
            pc_q         <= '0;
            pend_wb_en   <= 1'b0;
            pend_wb_val  <= '0;
            pend_pcadv   <= '0;
            done_o       <= 1'b0;
            err_o        <= 1'b0;
            reg_direct_o <= 1'b0;
            ea_o         <= '0;
            wb_en_o      <= 1'b0;
            wb_idx_o     <= '0;
            wb_val_o     <= '0;
            pc_adv_o     <= '0;
        end else begin
            state   <= nxt_state;
            raddr_q <= nxt_raddr;
            done_o  <= f.fin;
            if (state == ST_IDLE && start_i) begin
                mode_q      <= s_mode;
                reg_q       <= s_ridx;
                byte_q      <= byte_i;
                base_q      <= s_base;
                pc_q        <= pc_i;
                pend_wb_en  <= st_wb_en;
                pend_wb_val <= st_wb_val;
                pend_pcadv  <= st_pcadv;
            end
            if (f.fin) begin
                err_o        <= fin_err;
                reg_direct_o <= f.rdir;
                ea_o         <= f.rdir ? '0 : fin_ea;
                wb_en_o      <= p_wb_en && !fin_err;
                wb_idx_o     <= p_idx;
                wb_val_o     <= p_wb_val;
                pc_adv_o     <= fin_err ? 3'd0 : p_pcadv;
            end
        end
    end

    assign busy_o    = (state != ST_IDLE);
    assign rd_req_o  = (state == ST_EXT) || (state == ST_PTR);
    assign rd_addr_o = raddr_q;

    // checks next to the logic they guard
    logic [W-1:0] wb_dlt;
    assign wb_dlt = wb_val_o - base_q;

    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
        done_o && err_o |-> !wb_en_o && (pc_adv_o == 3'd0));
    a_r9_word_aligned: assert property (@(posedge clk) disable iff (rst)
        done_o && !err_o && !reg_direct_o && !byte_q |-> !ea_o[0]);
    a_r1_direct_quiet: assert property (@(posedge clk) disable iff (rst)
        done_o && reg_direct_o |-> !wb_en_o && !err_o);
    a_r5_step_range: assert property (@(posedge clk) disable iff (rst)
        done_o && wb_en_o |-> (wb_dlt == W'(1)) || (wb_dlt == W'(2)) ||
                              (wb_dlt == {W{1'b1}}) || (wb_dlt == {{(W-2){1'b1}}, 2'b10}));
    a_r5_even_step: assert property (@(posedge clk) disable iff (rst)
        done_o && wb_en_o && (wb_idx_o >= RIW'(SP_IDX)) |-> (wb_val_o[0] == base_q[0]));
endmodule

// File: tb/test_opnd_ea_seq.sv
module test_opnd_ea_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [5:0]  spec_i = '0;
    logic        byte_i = 1'b0;
    logic [111:0] regs_i = '0;
    logic [15:0] pc_i = '0;
    logic        rd_req_o, rd_valid_i = 1'b0;
    logic [15:0] rd_addr_o, rd_data_i = '0;
    logic        busy_o, done_o, err_o, reg_direct_o, wb_en_o;
    logic [15:0] ea_o, wb_val_o;
    logic [2:0]  wb_idx_o, pc_adv_o;

    always #10 clk = ~clk;

    opnd_ea_seq i_opnd_ea_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .spec_i(spec_i), .byte_i(byte_i),
        .regs_i(regs_i), .pc_i(pc_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .reg_direct_o(reg_direct_o), .ea_o(ea_o),
        .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_val_o(wb_val_o), .pc_adv_o(pc_adv_o)
    );

    int errors = 0;
    int checks = 0;
    int rd_lat = 0;
    logic [15:0] regs_b [7];
    logic [15:0] got_addrs [$];
    logic [15:0] e_addrs [$];
    logic [15:0] e_ea, e_wbval;
    logic        e_err, e_rdir, e_wben, e_simple;
    logic [2:0]  e_wbidx, e_pcadv;

    function automatic logic [15:0] mem_f(logic [15:0] a);
        if (a == 16'h0300) return 16'h1235;
        return (a * 16'd3 + 16'h0040) & 16'hFFFE;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // memory responder with programmable wait
    initial begin
        int cnt = 0;
        bit prev_wait = 0;
        logic [15:0] prev_addr = '0;
        forever begin
            @(negedge clk);
            if (rd_req_o && prev_wait) chk("R10 address held while waiting", rd_addr_o, prev_addr);
            if (rd_valid_i) begin
                rd_valid_i = 1'b0;
                cnt = 0;
            end else if (rd_req_o) begin
                if (cnt >= rd_lat) begin
                    rd_valid_i = 1'b1;
                    rd_data_i  = mem_f(rd_addr_o);
                    got_addrs.push_back(rd_addr_o);
                end else cnt++;
            end
            prev_wait = rd_req_o && !rd_valid_i;
            prev_addr = rd_addr_o;
        end
    end

    // behavioural reference
    task automatic model(input int md, input int rg, input bit byt);
        logic [15:0] b, v, x;
        int step;
        e_ea = '0; e_err = 0; e_rdir = 0; e_wben = 0; e_wbidx = 3'(rg); e_wbval = '0; e_pcadv = 0;
        e_addrs.delete();
        e_simple = (md == 0 || md == 1 || md == 2 || md == 4);
        b = (rg == 7) ? pc_i : regs_b[rg];
        step = (!byt || rg >= 6 || md == 3 || md == 5) ? 2 : 1;
        case (md)
            0: e_rdir = 1;
            1: e_ea = b;
            2: begin
                e_ea = b;
                if (rg == 7) e_pcadv = 2; else begin e_wben = 1; e_wbval = b + 16'(step); end
            end
            3: begin
                if (rg == 7) e_pcadv = 2; else begin e_wben = 1; e_wbval = b + 16'd2; end
                if (b[0]) e_err = 1; else begin e_addrs.push_back(b); e_ea = mem_f(b); end
            end
            4: begin v = b - 16'(step); e_ea = v; e_wben = 1; e_wbval = v; end
            5: begin
                v = b - 16'd2; e_wben = 1; e_wbval = v;
                if (v[0]) e_err = 1; else begin e_addrs.push_back(v); e_ea = mem_f(v); end
            end
            default: begin
                e_pcadv = 2;
                if (pc_i[0]) e_err = 1;
                else begin
                    e_addrs.push_back(pc_i);
                    x = mem_f(pc_i);
                    v = ((rg == 7) ? pc_i + 16'd2 : b) + x;
                    if (md == 6) e_ea = v;
                    else if (v[0]) e_err = 1;
                    else begin e_addrs.push_back(v); e_ea = mem_f(v); end
                end
            end
        endcase
        if (!e_err && !e_rdir && !byt && e_ea[0]) e_err = 1;
        if (e_err) begin e_wben = 0; e_pcadv = 0; end
    endtask

    task automatic run_op(input string tag, input int md, input int rg, input bit byt,
                          input int lat, input bit poke);
        int cyc = 0;
        model(md, rg, byt);
        got_addrs.delete();
        rd_lat = lat;
        @(negedge clk);
        spec_i = {3'(md), 3'(rg)}; byte_i = byt; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin start_i = 1'b1; spec_i = 6'o00; byte_i = 1'b0; end
        if (e_simple) chk({tag, " done in cycle after start"}, 16'(done_o), 16'd1);
        while (!done_o && cyc < 60) begin
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        chk({tag, " completion seen"}, 16'(done_o), 16'd1);
        chk({tag, " err"}, 16'(err_o), 16'(e_err));
        chk({tag, " reg_direct"}, 16'(reg_direct_o), 16'(e_rdir));
        if (!e_err && !e_rdir) chk({tag, " ea"}, ea_o, e_ea);
        chk({tag, " wb_en"}, 16'(wb_en_o), 16'(e_wben));
        if (e_wben) begin
            chk({tag, " wb_idx"}, 16'(wb_idx_o), 16'(e_wbidx));
            chk({tag, " wb_val"}, wb_val_o, e_wbval);
        end
        chk({tag, " pc_adv"}, 16'(pc_adv_o), 16'(e_pcadv));
        chk({tag, " R10 read count"}, 16'(got_addrs.size()), 16'(e_addrs.size()));
        for (int i = 0; i < e_addrs.size() && i < got_addrs.size(); i++)
            chk({tag, " R10 read address"}, got_addrs[i], e_addrs[i]);
        @(negedge clk);
        chk({tag, poke ? " R11 single completion" : " done is a pulse"}, 16'(done_o), 16'd0);
        chk({tag, " idle after"}, 16'(busy_o), 16'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        regs_b[0] = 16'h1000; regs_b[1] = 16'h2001; regs_b[2] = 16'h0300;
        regs_b[3] = 16'h4000; regs_b[4] = 16'h0010; regs_b[5] = 16'h7FFE;
        regs_b[6] = 16'h0F00;
        for (int i = 0; i < 7; i++) regs_i[i*16 +: 16] = regs_b[i];
        pc_i = 16'h0200;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 busy after reset", 16'(busy_o), 16'd0);
        chk("R12 done after reset", 16'(done_o), 16'd0);
        chk("R12 rd_req after reset", 16'(rd_req_o), 16'd0);

        run_op("R1 register direct",        0, 3, 0, 0, 0);
        run_op("R2 deferred word",          1, 0, 0, 0, 0);
        run_op("R9 odd word address",       1, 1, 0, 0, 0);
        run_op("R2 deferred odd byte",      1, 1, 1, 0, 0);
        run_op("R3 R5 postinc byte",        2, 0, 1, 0, 0);
        run_op("R3 postinc word",           2, 0, 0, 0, 0);
        run_op("R5 postinc byte via SP",    2, 6, 1, 0, 0);
        run_op("R5 postinc byte R5",        2, 5, 1, 0, 0);
        run_op("R8 immediate",              2, 7, 0, 0, 0);
        run_op("R4 R5 predec byte",         4, 3, 1, 0, 0);
        run_op("R4 predec word",            4, 3, 0, 0, 0);
        run_op("R8 predec PC",              4, 7, 0, 0, 0);
        run_op("R6 postinc pointer byte",   3, 0, 1, 1, 0);
        run_op("R9 odd pointer value",      3, 2, 0, 0, 0);
        run_op("R9 odd pointer address",    3, 1, 0, 0, 0);
        run_op("R6 predec pointer",         5, 4, 0, 2, 0);
        run_op("R7 indexed",                6, 4, 0, 2, 0);
        run_op("R8 PC relative",            6, 7, 0, 0, 0);
        run_op("R7 indexed pointer",        7, 0, 0, 1, 0);
        run_op("R8 PC relative pointer",    7, 7, 1, 0, 0);
        run_op("R8 absolute",               3, 7, 0, 0, 0);
        run_op("R11 start while busy",      6, 4, 0, 3, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule